// File: doc/BRIEF.md
# Synchronous Burst Cache SRAM

This block is a single-clock synchronous SRAM meant to sit beside a processor as a secondary cache array. Each word is 18 bits wide and is kept as two 9-bit halves. The halves share one bidirectional data bus, and each half has its own write enable. The address width is a parameter. It is set to 16 for a 64K-word array. The default is a smaller array so that elaboration stays light.

A burst can be opened by either of two strobes, one from the processor and one from the cache controller. The block captures the full address on that edge. From then on it generates only the two lowest address bits itself, using a 2-bit counter that wraps inside an aligned group of four. The counter moves only on edges where the advance input is high.

A build parameter selects how those two bits are formed:
- interleaved order: the captured low bits XOR the count.
- linear order: the captured low bits plus the count, modulo 4.

Chip select is sampled on the clock edge. Output enable acts at once, without waiting for a clock. Writes complete on the clock edge and need no externally timed pulse.

Top module: `csram_top`

## Requirements
- R1: `we_hi_i` writes bits 17:9 of the addressed word and `we_lo_i` writes bits 8:0. The half whose enable is low keeps its stored value.
- R2: On an edge where chip select is high and either strobe is high, the block captures the whole address and resets the burst count to 0. The word accessed on that edge is the one at `addr_i`.
- R3: Each edge with chip select high, advance high and no strobe adds 1 to the burst count. The count wraps after four steps, so the fifth access returns to the start word. Only the two lowest address bits change.
- R4: On an edge with no strobe and no advance, the address holds, and a read returns the same word again.
- R5: With `ORDER = ORDER_INTERLEAVE`, the low two address bits for count k are start XOR k. A start of 1 gives 1,0,3,2, and a start of 3 gives 3,2,1,0.
- R6: With `ORDER = ORDER_LINEAR`, the low two address bits for count k are (start + k) mod 4. A start of 1 gives 1,2,3,0, and a start of 3 gives 3,0,1,2.
- R7: Read data is driven on `data_io` during the cycle that follows a read edge, and only if that edge had chip select high and `oe_i` is high. The bus is released as soon as `oe_i` falls. After reset the bus is released.
- R8: An edge with chip select low does nothing: strobes are ignored, the counter holds, nothing is written, and the bus is released for the next cycle.
- R9: A processor-strobe edge is always a read, whatever the write enables are.
- R10: When both strobes are high on the same edge, the processor strobe wins and the edge is a read.
- R11: A strobe during a running burst restarts the burst at the new address, with the count set back to 0.
- R12: Writes happen only on controller-strobe edges or advance edges that have a write enable high. They use the address of that edge. Write enables on hold edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address, captured when a strobe is high |
| proc_strb_i | input | 1 | Processor burst-start strobe (read start) |
| ctrl_strb_i | input | 1 | Controller burst-start strobe |
| adv_i | input | 1 | Step the burst counter |
| cs_i | input | 1 | Synchronous chip select |
| we_hi_i | input | 1 | Write enable, upper half |
| we_lo_i | input | 1 | Write enable, lower half |
| oe_i | input | 1 | Asynchronous output enable |
| data_io | inout | 2*HALF_W | Common data bus |

## Verification
A strobe, the advance input and the write enables can all be high on the same edge. The bench drives these overlaps on purpose.

In one case both strobes are high together with the write enables, which must give a read. In another, the processor strobe is high while chip select is low, which must change nothing. In a third, a controller strobe arrives in the middle of a burst, which must reload the counter.

Each overlap is judged by the word that appears on the bus in the following cycle. A hold read afterwards shows whether the array or the counter was disturbed. Two instances, one built for each burst order, get the same stimulus. Each is compared against the order its parameter selects.

// File: rtl/csram_pkg.sv
package csram_pkg;
  typedef enum logic {
    ORDER_INTERLEAVE = 1'b0,
    ORDER_LINEAR     = 1'b1
  } burst_order_e;
endpackage

// File: rtl/csram_burst_ctr.sv
module csram_burst_ctr
  import csram_pkg::*;
#(
  parameter burst_order_e ORDER = ORDER_INTERLEAVE,
  parameter int           LOW_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [LOW_W-1:0] start_low_i,
  output logic [LOW_W-1:0] low_o
);
  logic [LOW_W-1:0] base_q, base_nxt;
  logic [LOW_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    base_nxt = load_i ? start_low_i : base_q;
    if (load_i)      cnt_nxt = '0;
    else if (step_i) cnt_nxt = cnt_q + 1'b1;
    else             cnt_nxt = cnt_q;
  end

  // address bits used on this same edge
  generate
    if (ORDER == ORDER_LINEAR) begin : g_linear
      assign low_o = base_nxt + cnt_nxt;
    end else begin : g_interleave
      assign low_o = base_nxt ^ cnt_nxt;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  AST_CNT_LOAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == '0)); // R2
  AST_CNT_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (cnt_q == LOW_W'($past(cnt_q) + 1'b1))); // R3
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> ($stable(cnt_q) && $stable(base_q))); // R4
endmodule

// File: rtl/csram_half_bank.sv
module csram_half_bank #(
  parameter int ADDR_W = 10,
  parameter int HALF_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              rd_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [HALF_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= mem_q[addr_i];
  end

  AST_HALF_RW_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> !rd_i); // R12
endmodule

// File: rtl/csram_top.sv
module csram_top
  import csram_pkg::*;
#(
  parameter int           ADDR_W = 10,
  parameter int           HALF_W = 9,
  parameter burst_order_e ORDER  = ORDER_INTERLEAVE
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  proc_strb_i,
  input  logic                  ctrl_strb_i,
  input  logic                  adv_i,
  input  logic                  cs_i,
  input  logic                  we_hi_i,
  input  logic                  we_lo_i,
  input  logic                  oe_i,
  inout  wire  [2*HALF_W-1:0]   data_io
);
  localparam int LOW_W  = 2;
  localparam int HI_W   = ADDR_W - LOW_W;
  localparam int DATA_W = 2 * HALF_W;
  localparam int HALVES = 2;

  logic              proc_go, ctrl_go, start, step;
  logic              wr_cyc, rd_cyc;
  logic [HI_W-1:0]   hi_q, hi_nxt;
  logic [LOW_W-1:0]  low_cur;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] dout;
  logic              drv_q;
  logic [HALVES-1:0] half_we;

  assign proc_go = cs_i & proc_strb_i;
  assign ctrl_go = cs_i & ctrl_strb_i & ~proc_strb_i;  // processor strobe wins
  assign start   = proc_go | ctrl_go;
  assign step    = cs_i & adv_i & ~start;
  assign wr_cyc  = (ctrl_go | step) & (we_hi_i | we_lo_i);
  assign rd_cyc  = cs_i & ~wr_cyc;
  assign half_we = {we_hi_i, we_lo_i} & {HALVES{wr_cyc}};

  assign hi_nxt   = start ? addr_i[ADDR_W-1:LOW_W] : hi_q;
  assign acc_addr = {hi_nxt, low_cur};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      drv_q <= 1'b0;
    end else begin
      hi_q  <= hi_nxt;
      drv_q <= rd_cyc;
    end
  end

  csram_burst_ctr #(
    .ORDER (ORDER),
    .LOW_W (LOW_W)
  ) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start),
    .step_i      (step),
    .start_low_i (addr_i[LOW_W-1:0]),
    .low_o       (low_cur)
  );

  generate
    for (genvar h = 0; h < HALVES; h++) begin : g_half
      csram_half_bank #(
        .ADDR_W (ADDR_W),
        .HALF_W (HALF_W)
      ) u_bank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .addr_i  (acc_addr),
        .we_i    (half_we[h]),
        .rd_i    (rd_cyc),
        .wdata_i (data_io[h*HALF_W +: HALF_W]),
        .rdata_o (dout[h*HALF_W +: HALF_W])
      );
    end
  endgenerate

  assign data_io = (drv_q && oe_i) ? dout : {DATA_W{1'bz}};

  AST_PROC_IS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && proc_strb_i) |=> drv_q); // R9
  AST_DESEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> !drv_q); // R8
  AST_WR_NOT_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|half_we) |=> !drv_q); // R12
endmodule

// File: tb/csram_top_tb_top.sv
module csram_top_tb_top;
  import csram_pkg::*;
  localparam int AW = 10;
  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ps = 1'b0, cc = 1'b0, adv = 1'b0, cs = 1'b0;
  logic          weh = 1'b0, wel = 1'b0, oe = 1'b0;
  logic          tb_en = 1'b0;
  logic [DW-1:0] tb_val = '0;
  wire  [DW-1:0] bus_a, bus_b;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [DW-1:0] exp_mem [1 << AW];
  logic [AW-1:0] last_a, last_b;

  always #5 clk = ~clk;

  assign bus_a = tb_en ? tb_val : {DW{1'bz}};
  assign bus_b = tb_en ? tb_val : {DW{1'bz}};

  csram_top #(.ADDR_W(AW), .HALF_W(9), .ORDER(ORDER_INTERLEAVE)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .proc_strb_i(ps), .ctrl_strb_i(cc),
    .adv_i(adv), .cs_i(cs), .we_hi_i(weh), .we_lo_i(wel), .oe_i(oe), .data_io(bus_a));

  csram_top #(.ADDR_W(AW), .HALF_W(9), .ORDER(ORDER_LINEAR)) dut_lin_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .proc_strb_i(ps), .ctrl_strb_i(cc),
    .adv_i(adv), .cs_i(cs), .we_hi_i(weh), .we_lo_i(wel), .oe_i(oe), .data_io(bus_b));

  function automatic logic [DW-1:0] pat(logic [AW-1:0] a);
    return {~a[8:0], a[8:0]};
  endfunction

  function automatic logic [AW-1:0] seq(bit lin, logic [AW-1:0] s, int k);
    logic [1:0] kk;
    kk = 2'(k);
    return {s[AW-1:2], lin ? 2'(s[1:0] + kk) : (s[1:0] ^ kk)};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic chk_last(string req);
    chk({req, " interleave"}, bus_a, exp_mem[last_a]);
    chk({req, " linear"}, bus_b, exp_mem[last_b]);
  endtask

  // both buses must be released: tb drives zero, any DUT drive shows as nonzero
  task automatic chk_released(string req);
    tb_en = 1'b1; tb_val = '0; #1;
    chk({req, " interleave released"}, bus_a, '0);
    chk({req, " linear released"}, bus_b, '0);
    tb_en = 1'b0; #1;
  endtask

  task automatic go_idle();
    ps = 0; cc = 0; adv = 0; cs = 0; weh = 0; wel = 0; tb_en = 0;
  endtask

  task automatic t_reset();
    oe = 1'b1;
    chk_released("R7 reset");
  endtask

  // aligned base, so both orders visit base..base+3
  task automatic t_write_block(logic [AW-1:0] base);
    for (int k = 0; k < 4; k++) begin
      cs = 1; cc = (k == 0); adv = (k != 0); weh = 1; wel = 1; oe = 0;
      addr = base; tb_en = 1; tb_val = pat(AW'(base + k));
      tick();
      exp_mem[AW'(base + k)] = pat(AW'(base + k));
    end
    go_idle();
    tick();
  endtask

  task automatic t_read_burst(logic [AW-1:0] s, int n, string req);
    cs = 1; ps = 1; oe = 1; addr = s; tb_en = 0;
    tick();
    last_a = s; last_b = s;
    chk_last({"R2 start ", req});
    ps = 0; adv = 1;
    for (int k = 1; k <= n; k++) begin
      tick();
      last_a = seq(0, s, k); last_b = seq(1, s, k);
      chk_last({req, (k == 4) ? " R3 wrap" : " R3 step"});
    end
    adv = 0;
  endtask

  task automatic t_orders();
    t_read_burst(AW'(10'h041), 4, "R5 R6 start1");
    t_read_burst(AW'(10'h083), 4, "R5 R6 start3");
  endtask

  task automatic t_hold();
    t_read_burst(AW'(10'h042), 1, "R5 R6 start2");
    tick();
    chk_last("R4 hold");
    // write enables on a hold edge must not write
    oe = 0; weh = 1; wel = 1; tb_en = 1; tb_val = 18'h15555;
    tick();
    weh = 0; wel = 0; tb_en = 0; oe = 1;
    tick();
    chk_last("R12 hold write ignored");
  endtask

  task automatic t_oe_async();
    t_read_burst(AW'(10'h040), 0, "R7 base");
    oe = 0; #1;
    chk_released("R7 oe low");
    oe = 1; #1;
    chk_last("R7 oe high");
  endtask

  task automatic t_desel();
    t_read_burst(AW'(10'h041), 1, "R8 prep");
    cs = 0; ps = 1; addr = AW'(10'h080);
    tick();
    ps = 0;
    chk_released("R8 deselect");
    cs = 1;
    tick();
    chk_last("R8 strobe ignored");
    go_idle();
  endtask

  task automatic t_proc_write(bit both, string req);
    cs = 1; ps = 1; cc = both; weh = 1; wel = 1; oe = 0;
    addr = both ? AW'(10'h081) : AW'(10'h080); tb_en = 1; tb_val = 18'h00001;
    tick();
    last_a = addr; last_b = addr;
    ps = 0; cc = 0; weh = 0; wel = 0; tb_en = 0; oe = 1; #1;
    chk_last({req, " read"});
    tick();
    chk_last({req, " array unchanged"});
    go_idle();
  endtask

  task automatic t_restart();
    t_read_burst(AW'(10'h041), 1, "R11 prep");
    cs = 1; cc = 1; addr = AW'(10'h083);
    tick();
    cc = 0;
    last_a = AW'(10'h083); last_b = AW'(10'h083);
    chk_last("R11 restart");
    adv = 1;
    tick();
    adv = 0;
    last_a = AW'(10'h082); last_b = AW'(10'h080);
    chk_last("R11 count reloaded");
    go_idle();
  endtask

  task automatic t_bytes();
    cs = 1; cc = 1; addr = AW'(10'h040); weh = 1; wel = 0; oe = 0;
    tb_en = 1; tb_val = 18'h3FFFF;
    tick();
    exp_mem[10'h040] = {9'h1FF, exp_mem[10'h040][8:0]};
    cc = 0; adv = 1; weh = 0; wel = 1; tb_val = 18'h00000;
    tick();
    exp_mem[10'h041] = {exp_mem[10'h041][17:9], 9'h000};
    go_idle();
    tick();
    t_read_burst(AW'(10'h040), 1, "R1 halves");
    go_idle();
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_block(AW'(10'h040));
    t_write_block(AW'(10'h080));
    t_orders();
    t_hold();
    t_oe_async();
    t_desel();
    t_proc_write(1'b0, "R9 proc strobe with write enables");
    t_proc_write(1'b1, "R10 both strobes");
    t_restart();
    t_bytes();
    done = 1'b1;
    finish_run();
  end
endmodule